// File: doc/BRIEF.md
# Floating-Point Compare with Condition Flags

This block orders two floating-point operands, in either a narrow (single) or wide (double) binary format, and turns the outcome into a four-bit N/Z/C/V code. Integer conditional execution can test that code for the usual relational predicates once a later transfer step has copied it into the integer status flags. The block handles signed zeros, infinities, subnormals and NaNs. When a NaN is present the outcome is "unordered".

A mode input chooses the kind of compare. A quiet compare raises the invalid-operation flag only for a signalling NaN. A signalling compare raises it for any NaN. A second input chooses the format. In narrow mode the operand sits in the low bits of each operand port. The code and the invalid flag are registered, and they appear together with a valid strobe one clock after the input strobe. They then stay as they are until the next strobe. Default-NaN handling plays no part in a compare.

Top module: `fp_compare_flags`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction nonzero), the code is unordered, NZCV = 0011.
- R2: Operands of equal value give NZCV = 0110. Plus zero and minus zero are equal.
- R3: If a is less than b, NZCV = 1000; if a is greater than b, NZCV = 0010. Ordering follows real value, across signs, infinities and subnormals.
- R4: With the quiet compare (sig_cmp = 0), invalid is 1 exactly when at least one operand is a signalling NaN, that is, a NaN whose top fraction bit is 0.
- R5: With the signalling compare (sig_cmp = 1), invalid is 1 exactly when at least one operand is a NaN of either kind.
- R6: With wide_fmt = 0, only the low 1+SP_EXP_W+SP_FRAC_W bits of each operand are used, and the upper bits have no effect on the result.
- R7: res_valid is high in exactly the cycles that follow a cycle with cmp_valid high, and it carries the result of that request.
- R8: While cmp_valid is low, nzcv and invalid hold their last values, whatever the operand inputs do.
- R9: After reset, res_valid = 0, nzcv = 0000 and invalid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare request strobe |
| wide_fmt | input | 1 | 1 selects the wide format, 0 selects the narrow format |
| sig_cmp | input | 1 | 1 selects the signalling compare, 0 selects the quiet compare |
| op_a | input | 1+DP_EXP_W+DP_FRAC_W | First operand |
| op_b | input | 1+DP_EXP_W+DP_FRAC_W | Second operand |
| res_valid | output | 1 | Result strobe, one cycle after cmp_valid |
| nzcv | output | 4 | Registered condition code {N,Z,C,V} |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
The timing assertions assume that cmp_valid is low while reset is held, so the first result strobe after reset follows a real request. The bench keeps cmp_valid low during reset and only raises it at falling edges. The bench shrinks both formats to a few exponent and fraction bits. It then sweeps every narrow operand pair in both compare modes, with junk in the unused upper bits, and every wide operand pair. Each operand's real value is rebuilt as a scaled signed integer, which gives the expected code.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  localparam logic [3:0] NZCV_LT = 4'b1000;
  localparam logic [3:0] NZCV_EQ = 4'b0110;
  localparam logic [3:0] NZCV_GT = 4'b0010;
  localparam logic [3:0] NZCV_UN = 4'b0011;

  function automatic logic [3:0] rel_to_nzcv(input rel_e r);
    case (r)
      REL_LT:  return NZCV_LT;
      REL_EQ:  return NZCV_EQ;
      REL_GT:  return NZCV_GT;
      default: return NZCV_UN;
    endcase
  endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op,
  output logic         sign,
  output logic [W-2:0] mag,
  output logic         is_nan,
  output logic         is_snan,
  output logic         is_zero
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign sign   = op[W-1];
  assign exp_f  = op[W-2:FRAC_W];
  assign frac_f = op[FRAC_W-1:0];
  // Exponent and fraction together give an unsigned key that is monotonic in magnitude
  assign mag     = op[W-2:0];
  assign is_nan  = (&exp_f) && (|frac_f);
  assign is_snan = is_nan && !frac_f[FRAC_W-1];
  assign is_zero = (exp_f == '0) && (frac_f == '0);
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             sign_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic             nan_a,
  input  logic             zero_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             nan_b,
  input  logic             zero_b,
  output rel_e             rel
);
  logic mag_lt;
  assign mag_lt = mag_a < mag_b;

  always_comb begin
    if (nan_a || nan_b)              rel = REL_UN;
    else if (zero_a && zero_b)       rel = REL_EQ;
    else if (sign_a != sign_b)       rel = sign_a ? REL_LT : REL_GT;
    else if (mag_a == mag_b)         rel = REL_EQ;
    else if (mag_lt ^ sign_a)        rel = REL_LT;
    else                             rel = REL_GT;
  end
endmodule

// File: rtl/fpcmp_result_reg.sv
module fpcmp_result_reg
  import fpcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  rel_e       rel,
  input  logic       raise_inv,
  output logic       res_valid,
  output logic [3:0] nzcv,
  output logic       invalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      nzcv      <= 4'b0000;
      invalid   <= 1'b0;
    end else begin
      res_valid <= load;
      if (load) begin
        nzcv    <= rel_to_nzcv(rel);
        invalid <= raise_inv;
      end
    end
  end

  // R7: strobe follows request by one cycle
  p_valid_after_req_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> res_valid);
  p_no_spurious_valid_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> !res_valid);
  // R8: outputs hold without a request
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(nzcv) && $stable(invalid)));
  // R3: only the four legal codes appear with a strobe
  p_legal_code_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (nzcv == NZCV_LT || nzcv == NZCV_EQ ||
                   nzcv == NZCV_GT || nzcv == NZCV_UN));
  // R1: invalid only ever accompanies an unordered code
  p_inv_unordered_r1: assert property (@(posedge clk) disable iff (rst)
    invalid |-> (nzcv == NZCV_UN));
endmodule

// File: rtl/fp_compare_flags.sv
module fp_compare_flags
  import fpcmp_pkg::*;
#(
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23,
  parameter int DP_EXP_W  = 11,
  parameter int DP_FRAC_W = 52,
  localparam int SW       = 1 + SP_EXP_W + SP_FRAC_W,
  localparam int DW       = 1 + DP_EXP_W + DP_FRAC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_valid,
  input  logic          wide_fmt,
  input  logic          sig_cmp,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          res_valid,
  output logic [3:0]    nzcv,
  output logic          invalid
);
  localparam int SMAG_W = SW - 1;
  localparam int DMAG_W = DW - 1;
  localparam int PAD_W  = DMAG_W - SMAG_W;

  logic [DW-1:0]     ops    [2];
  logic              n_sign [2], n_nan [2], n_snan [2], n_zero [2];
  logic [SMAG_W-1:0] n_mag  [2];
  logic              w_sign [2], w_nan [2], w_snan [2], w_zero [2];
  logic [DMAG_W-1:0] w_mag  [2];
  logic              s_sign [2], s_nan [2], s_snan [2], s_zero [2];
  logic [DMAG_W-1:0] s_mag  [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    fpcmp_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_cls_n (
      .op      (ops[k][SW-1:0]),
      .sign    (n_sign[k]),
      .mag     (n_mag[k]),
      .is_nan  (n_nan[k]),
      .is_snan (n_snan[k]),
      .is_zero (n_zero[k])
    );
    fpcmp_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_cls_w (
      .op      (ops[k]),
      .sign    (w_sign[k]),
      .mag     (w_mag[k]),
      .is_nan  (w_nan[k]),
      .is_snan (w_snan[k]),
      .is_zero (w_zero[k])
    );
    // Zero-extending the narrow key keeps its ordering within the narrow format
    assign s_sign[k] = wide_fmt ? w_sign[k] : n_sign[k];
    assign s_mag[k]  = wide_fmt ? w_mag[k]  : {{PAD_W{1'b0}}, n_mag[k]};
    assign s_nan[k]  = wide_fmt ? w_nan[k]  : n_nan[k];
    assign s_snan[k] = wide_fmt ? w_snan[k] : n_snan[k];
    assign s_zero[k] = wide_fmt ? w_zero[k] : n_zero[k];
  end

  rel_e rel;
  logic any_nan, any_snan, raise_inv;

  fpcmp_order #(.MAG_W(DMAG_W)) u_order (
    .sign_a (s_sign[0]),
    .mag_a  (s_mag[0]),
    .nan_a  (s_nan[0]),
    .zero_a (s_zero[0]),
    .sign_b (s_sign[1]),
    .mag_b  (s_mag[1]),
    .nan_b  (s_nan[1]),
    .zero_b (s_zero[1]),
    .rel    (rel)
  );

  assign any_nan   = s_nan[0]  || s_nan[1];
  assign any_snan  = s_snan[0] || s_snan[1];
  assign raise_inv = any_snan || (sig_cmp && any_nan);

  fpcmp_result_reg u_res (
    .clk       (clk),
    .rst       (rst),
    .load      (cmp_valid),
    .rel       (rel),
    .raise_inv (raise_inv),
    .res_valid (res_valid),
    .nzcv      (nzcv),
    .invalid   (invalid)
  );

  // R1: a NaN operand always yields the unordered code
  p_nan_unordered_r1: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && any_nan) |=> (nzcv == NZCV_UN));
  // R1: no NaN never yields unordered
  p_num_ordered_r1: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !any_nan) |=> (nzcv != NZCV_UN));
  // R4: quiet compare without a signalling NaN leaves invalid low
  p_quiet_no_inv_r4: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !sig_cmp && !any_snan) |=> !invalid);
  // R4: a signalling NaN raises invalid in either mode
  p_snan_inv_r4: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && any_snan) |=> invalid);
  // R5: signalling compare raises invalid for any NaN
  p_sig_any_nan_r5: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && sig_cmp && any_nan) |=> invalid);
  // R2: two zeros of any sign compare equal
  p_zeros_equal_r2: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && s_zero[0] && s_zero[1]) |=> (nzcv == NZCV_EQ));
endmodule

// File: tb/fp_compare_flags_tb.sv
module fp_compare_flags_tb;
  localparam int SE = 3, SF = 2, DE = 4, DF = 3;
  localparam int DW = 1 + DE + DF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmp_valid = 1'b0;
  logic          wide_fmt = 1'b0;
  logic          sig_cmp = 1'b0;
  logic [DW-1:0] op_a = '0;
  logic [DW-1:0] op_b = '0;
  logic          res_valid;
  logic [3:0]    nzcv;
  logic          invalid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fp_compare_flags #(.SP_EXP_W(SE), .SP_FRAC_W(SF), .DP_EXP_W(DE), .DP_FRAC_W(DF)) u_dut (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .wide_fmt(wide_fmt),
    .sig_cmp(sig_cmp), .op_a(op_a), .op_b(op_b),
    .res_valid(res_valid), .nzcv(nzcv), .invalid(invalid));

  // Scaled signed real value plus NaN kind, from the format rules alone
  task automatic decode(input int x, input bit wide, output longint val,
                        output bit nan, output bit snan);
    int ew, fw, s, e, fr;
    longint key;
    ew = wide ? DE : SE;
    fw = wide ? DF : SF;
    x  = x & ((1 << (1 + ew + fw)) - 1);
    s  = (x >> (ew + fw)) & 1;
    e  = (x >> fw) & ((1 << ew) - 1);
    fr = x & ((1 << fw) - 1);
    nan  = (e == (1 << ew) - 1) && (fr != 0);
    snan = nan && (((fr >> (fw - 1)) & 1) == 0);
    if (e == (1 << ew) - 1) key = 64'd1 << 40;
    else if (e == 0)        key = fr;
    else                    key = longint'((1 << fw) + fr) << (e - 1);
    val = s ? -key : key;
  endtask

  task automatic expect_cmp(input int a, input int b, input bit wide, input bit sig,
                            output logic [3:0] f, output logic inv);
    longint va, vb;
    bit na, nb, sa, sb;
    decode(a, wide, va, na, sa);
    decode(b, wide, vb, nb, sb);
    if (na || nb)      f = 4'b0011;
    else if (va == vb) f = 4'b0110;
    else if (va < vb)  f = 4'b1000;
    else               f = 4'b0010;
    inv = sa || sb || (sig && (na || nb));
  endtask

  // Drive at a falling edge, result checked at the next falling edge
  task automatic run_cmp(input int a, input int b, input bit wide, input bit sig);
    logic [3:0] ef;
    logic ei;
    string tag;
    expect_cmp(a, b, wide, sig, ef, ei);
    op_a = DW'(a); op_b = DW'(b); wide_fmt = wide; sig_cmp = sig; cmp_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (ef == 4'b0011) tag = "R1";
    else if (ef == 4'b0110) tag = "R2";
    else tag = "R3";
    if (!wide) tag = {tag, "/R6"};
    if (res_valid !== 1'b1) begin
      errors++;
      $display("FAIL R7 res_valid a=%h b=%h actual=%b expected=1", a, b, res_valid);
    end else if (nzcv !== ef) begin
      errors++;
      $display("FAIL %s nzcv a=%h b=%h wide=%0d actual=%b expected=%b", tag, a, b, wide, nzcv, ef);
    end else if (invalid !== ei) begin
      errors++;
      $display("FAIL %s invalid a=%h b=%h sig=%0d actual=%b expected=%b",
               sig ? "R5" : "R4", a, b, sig, invalid, ei);
    end
  endtask

  initial begin
    logic [3:0] held_f;
    logic held_i;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || nzcv !== 4'b0000 || invalid !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset actual=%b/%b/%b expected=0/0000/0", res_valid, nzcv, invalid);
    end

    // Narrow format: all pairs, both modes, junk in the upper bits (R6)
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 64; i++)
        for (int j = 0; j < 64; j++)
          run_cmp(i | (((i + j + m) & 3) << 6), j | (((i ^ j) & 3) << 6), 1'b0, m[0]);

    // Wide format: all pairs, mode alternating
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        run_cmp(i, j, 1'b1, ((i + j) & 1) == 1);

    // Leave a quiet-NaN result in place with the signalling compare, then go idle
    run_cmp(8'h7D, 8'h01, 1'b1, 1'b1);
    held_f = nzcv;
    held_i = invalid;
    cmp_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      errors++;
      $display("FAIL R7 idle res_valid actual=%b expected=0", res_valid);
    end
    for (int k = 0; k < 4; k++) begin
      op_a = DW'(k * 37); op_b = DW'(k * 11); sig_cmp = k[0]; wide_fmt = k[1];
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (nzcv !== held_f || invalid !== held_i) begin
        errors++;
        $display("FAIL R8 hold actual=%b/%b expected=%b/%b", nzcv, invalid, held_f, held_i);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule